// File: doc/BRIEF.md
# Three-Wire Synchronous Shift Port

This block is a register-mapped serial shift unit for synchronous three-wire transfers. Firmware loads a byte into the shift register, selects where clock events come from, and then either strobes events one at a time or lets an external serial clock or a timer pulse drive them. The byte leaves on the data-out pin most significant bit first, while the data-in pin is shifted in behind it. A small edge counter counts every clock event and wraps once per byte. On the wrap it raises an overflow flag and copies the finished byte into a buffer register, so firmware can read it while the next transfer runs.

Each byte needs sixteen events: a sample event that latches the data-in pin, then a shift event that moves the register left with the latched bit entering at bit 0. For internal sources (software strobe, timer pulse) the counter parity picks the kind of event: an even count samples and an odd count shifts. With the external pin, rising edges sample and falling edges shift. The external pin passes through a synchronizer before edge detection. For master use, a toggle bit inverts the serial clock output, so firmware can produce the bus clock itself. Slave selection is left to general-purpose pins.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, all four registers read 0, and sdo and sck_out are 0.
- R2: Shifting and counting happen only when the wire-mode field (control bits [1:0]) holds 2'b01. With any other mode, clock events leave the count and the shift register unchanged.
- R3: The clock-select field (control bits [4:2]) takes these values: 3'b001 selects the software strobe (control bit 5), 3'b010 selects the timer pulse input, and 3'b011 selects both edges of sck_in. Any other value gives no clock. Events from a source that is not selected have no effect.
- R4: The count (status bits [3:0]) advances by one per clock event and wraps from 15 to 0. On the wrap the overflow flag (status bit 7) is set. A status write loads the count from bits [3:0] and clears the flag only when bit 7 is written as 1.
- R5: sdo always shows shift register bit 7. After sixteen events the shift register holds the eight sdi bits, first received bit in bit 7, and sdo has presented the loaded byte MSB first.
- R6: On the wrap, the buffer register (address 3) takes the shift register value after that event's shift. At all other times the buffer is unchanged, and writes to address 3 are ignored.
- R7: The strobe (bit 5) and toggle (bit 6) control bits act only in the cycle they are written and always read back as 0. Writing the toggle bit inverts sck_out, and writing both bits in one access does both actions.
- R8: A level change on sck_in becomes a counted event at the third rising clk edge after the change, and not earlier.
- R9: A bus write to the shift register (address 2) takes priority over a shift event in the same cycle. A status write takes priority over a count event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 shift data, 3 buffer |
| bus_we | input | 1 | Write enable for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| tmr_pulse | input | 1 | One-cycle timer compare-match pulse |
| sdi | input | 1 | Serial data in |
| sck_in | input | 1 | External serial clock (asynchronous) |
| sdo | output | 1 | Serial data out |
| sck_out | output | 1 | Software-toggled serial clock output |

## Verification
The bench builds the block with an 8-bit shift register (4-bit counter) and a two-stage synchronizer. At that size, a sweep can send every one of the 256 transmit values under software strobing, check each data-out bit as it appears, and check the received and buffered byte at each counter wrap. Shorter sweeps repeat the transfer with the timer pulse and the external pin as the clock source. The two-stage setting makes the three-edge latency of the external clock directly countable. Directed cases cover mode and source gating, the bus write priorities and the flag semantics.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        WM_OFF   = 2'b00,
        WM_THREE = 2'b01,
        WM_TWO   = 2'b10,
        WM_RSVD  = 2'b11
    } wire_mode_e;

    typedef enum logic [2:0] {
        CS_NONE   = 3'd0,
        CS_STROBE = 3'd1,
        CS_TIMER  = 3'd2,
        CS_EXTPIN = 3'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_STAT = 2'd1,
        RA_DATA = 2'd2,
        RA_BUF  = 2'd3
    } reg_addr_e;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       rsvd;
        logic       toggle;
        logic       strobe;
        clk_src_e   csel;
        wire_mode_e wmode;
    } ctrl_reg_t;

    typedef struct packed {
        logic fire;
        logic sample;
    } clk_evt_t;

    function automatic logic src_is_internal(clk_src_e s);
        return (s == CS_STROBE) || (s == CS_TIMER);
    endfunction

    function automatic ctrl_reg_t ctrl_keep(ctrl_reg_t c);
        ctrl_reg_t r;
        r        = c;
        r.rsvd   = 1'b0;
        r.toggle = 1'b0;
        r.strobe = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/ssp_clk_event.sv
module ssp_clk_event
    import ssp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  wire_mode_e wmode,
    input  clk_src_e   csel,
    input  logic       strobe_req,
    input  logic       tmr_pulse,
    input  logic       sck_in,
    input  logic       cnt_odd,
    output clk_evt_t   evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_lvl;
    logic                   pin_rise;
    logic                   pin_fall;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sck_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign pin_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= pin_lvl;
    end

    assign pin_rise = pin_lvl & ~prev_q;
    assign pin_fall = ~pin_lvl & prev_q;

    always_comb begin
        evt = '0;
        if (wmode == WM_THREE) begin
            case (csel)
                CS_STROBE: begin
                    evt.fire   = strobe_req;
                    evt.sample = ~cnt_odd;
                end
                CS_TIMER: begin
                    evt.fire   = tmr_pulse;
                    evt.sample = ~cnt_odd;
                end
                CS_EXTPIN: begin
                    evt.fire   = pin_rise | pin_fall;
                    evt.sample = pin_rise;
                end
                default: evt = '0;
            endcase
        end
    end

endmodule

// File: rtl/ssp_edge_counter.sv
module ssp_edge_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_fire,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             flag,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assign wrap = evt_fire && !load_en && (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (load_en)  cnt <= load_val;
        else if (evt_fire) cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  clk_evt_t          evt,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              wrap,
    input  logic              sdi,
    output logic [DATA_W-1:0] sreg,
    output logic [DATA_W-1:0] bufr
);

    logic              in_bit_q;
    logic              do_shift;
    logic [DATA_W-1:0] shift_nxt;

    assign do_shift  = evt.fire && !evt.sample;
    assign shift_nxt = {sreg[DATA_W-2:0], in_bit_q};

    always_ff @(posedge clk) begin
        if (rst)                         in_bit_q <= 1'b0;
        else if (evt.fire && evt.sample) in_bit_q <= sdi;
    end

    always_ff @(posedge clk) begin
        if (rst)           sreg <= '0;
        else if (wr_en)    sreg <= wr_val;
        else if (do_shift) sreg <= shift_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)       bufr <= '0;
        else if (wrap) bufr <= do_shift ? shift_nxt : sreg;
    end

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tmr_pulse,
    input  logic              sdi,
    input  logic              sck_in,
    output logic              sdo,
    output logic              sck_out
);

    localparam int CNT_W  = $clog2(2 * DATA_W);
    localparam int STAT_PAD = DATA_W - 1 - CNT_W;

    ctrl_reg_t         ctrl_q;
    ctrl_reg_t         ctrl_wr;
    ctrl_reg_t         ctrl_eff;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_data;
    logic              sck_q;
    clk_evt_t          evt;
    logic [CNT_W-1:0]  cnt_q;
    logic              flag_q;
    logic              wrap;
    logic [DATA_W-1:0] sreg_q;
    logic [DATA_W-1:0] bufr_q;

    assign ctrl_wr  = ctrl_reg_t'(bus_wdata[CTRL_W-1:0]);
    assign wr_ctrl  = bus_we && (reg_addr_e'(bus_addr) == RA_CTRL);
    assign wr_stat  = bus_we && (reg_addr_e'(bus_addr) == RA_STAT);
    assign wr_data  = bus_we && (reg_addr_e'(bus_addr) == RA_DATA);
    assign ctrl_eff = wr_ctrl ? ctrl_keep(ctrl_wr) : ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_keep(ctrl_wr);
    end

    always_ff @(posedge clk) begin
        if (rst)                            sck_q <= 1'b0;
        else if (wr_ctrl && ctrl_wr.toggle) sck_q <= ~sck_q;
    end

    ssp_clk_event #(
        .SYNC_STAGES(SYNC_STAGES)
    ) clk_event_i (
        .clk       (clk),
        .rst       (rst),
        .wmode     (ctrl_eff.wmode),
        .csel      (ctrl_eff.csel),
        .strobe_req(wr_ctrl && ctrl_wr.strobe),
        .tmr_pulse (tmr_pulse),
        .sck_in    (sck_in),
        .cnt_odd   (cnt_q[0]),
        .evt       (evt)
    );

    ssp_edge_counter #(
        .CNT_W(CNT_W)
    ) counter_i (
        .clk     (clk),
        .rst     (rst),
        .evt_fire(evt.fire),
        .load_en (wr_stat),
        .load_val(bus_wdata[CNT_W-1:0]),
        .flag_clr(wr_stat && bus_wdata[DATA_W-1]),
        .cnt     (cnt_q),
        .flag    (flag_q),
        .wrap    (wrap)
    );

    ssp_shifter #(
        .DATA_W(DATA_W)
    ) shifter_i (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .wr_en (wr_data),
        .wr_val(bus_wdata),
        .wrap  (wrap),
        .sdi   (sdi),
        .sreg  (sreg_q),
        .bufr  (bufr_q)
    );

    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_CTRL: bus_rdata = DATA_W'(ctrl_q);
            RA_STAT: bus_rdata = {flag_q, {STAT_PAD{1'b0}}, cnt_q};
            RA_DATA: bus_rdata = sreg_q;
            default: bus_rdata = bufr_q;
        endcase
    end

    assign sdo     = sreg_q[DATA_W-1];
    assign sck_out = sck_q;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              sck_out,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic [DATA_W-1:0] sreg,
    input logic [DATA_W-1:0] bufr,
    input logic [1:0]        wmode
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_pulse_bits_read_zero_R7: assert property (
        @(posedge clk) disable iff (rst)
        (bus_addr == 2'd0) |-> (!bus_rdata[5] && !bus_rdata[6]));

    assert_sck_only_on_toggle_R7: assert property (
        @(posedge clk) disable iff (rst)
        !$stable(sck_out) |-> $past(bus_we && bus_addr == 2'd0 && bus_wdata[6]));

    assert_count_single_step_R4: assert property (
        @(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == 2'd1)
        |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_flag_rises_on_wrap_R4: assert property (
        @(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cnt) == CNT_MAX && cnt == '0));

    assert_buffer_only_on_wrap_R6: assert property (
        @(posedge clk) disable iff (rst)
        !$stable(bufr) |-> ($past(cnt) == CNT_MAX && cnt == '0));

    assert_frozen_outside_mode_R2: assert property (
        @(posedge clk) disable iff (rst)
        (!bus_we && wmode != 2'b01) |=> ($stable(cnt) && $stable(sreg)));

endmodule

bind sync_shift_port ssp_checker #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .sck_out  (sck_out),
    .cnt      (cnt_q),
    .flag     (flag_q),
    .sreg     (sreg_q),
    .bufr     (bufr_q),
    .wmode    (ctrl_q.wmode)
);

// File: tb/sync_shift_port_tb.sv
`timescale 1ns/1ps
module sync_shift_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = 2'd0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       tmr = 1'b0;
    logic       sdi = 1'b0;
    logic       sck_in = 1'b0;
    logic       sdo;
    logic       sck_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sync_shift_port dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (addr),
        .bus_we   (we),
        .bus_wdata(wdata),
        .bus_rdata(rdata),
        .tmr_pulse(tmr),
        .sdi      (sdi),
        .sck_in   (sck_in),
        .sdo      (sdo),
        .sck_out  (sck_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr = 1'b1;
        @(negedge clk); tmr = 1'b0;
    endtask

    task automatic ext_edge();
        @(negedge clk); sck_in = ~sck_in;
        repeat (3) @(negedge clk);
    endtask

    // src: 0 strobe, 1 timer, 2 external pin
    task automatic fire_evt(input int src, input bit tog);
        if (src == 0)      bus_wr(2'd0, tog ? 8'h65 : 8'h25);
        else if (src == 1) pulse_tmr();
        else               ext_edge();
    endtask

    task automatic xfer(input int src, input logic [7:0] tx, input logic [7:0] rx,
                        input logic [7:0] prev_buf, input bit tog);
        logic [7:0] v;
        bus_wr(2'd0, (src == 0) ? 8'h05 : (src == 1) ? 8'h09 : 8'h0D);
        bus_wr(2'd2, tx);
        bus_wr(2'd1, 8'h80);
        for (int i = 0; i < 8; i++) begin
            sdi = rx[7-i];
            chk("R5 sdo bit", {7'd0, sdo}, {7'd0, tx[7-i]});
            fire_evt(src, tog);
            if (tog && i == 0) chk("R7 sck_out toggled", {7'd0, sck_out}, 8'h01);
            fire_evt(src, tog);
            if (i == 4) begin
                bus_rd(2'd3, v);
                chk("R6 buffer held mid-byte", v, prev_buf);
            end
        end
        bus_rd(2'd2, v); chk("R5 received byte", v, rx);
        bus_rd(2'd3, v); chk("R6 buffer captured", v, rx);
        bus_rd(2'd1, v); chk("R4 wrap flag and count", v, 8'h80);
        if (tog) chk("R7 sck_out back low", {7'd0, sck_out}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), v);
            chk("R1 reset register", v, 8'h00);
        end
        chk("R1 reset sdo", {7'd0, sdo}, 8'h00);
        chk("R1 reset sck_out", {7'd0, sck_out}, 8'h00);

        // R5/R6/R4 sweep with software strobe, every transmit value
        last = 8'h00;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] rx;
            rx = 8'((b * 37 + 11) & 8'hFF);
            xfer(0, 8'(b), rx, last, (b % 16) == 7);
            last = rx;
        end

        // R3 timer-pulse source
        for (int b = 0; b < 16; b++) begin
            logic [7:0] rx;
            rx = 8'(b * 29) ^ 8'h96;
            xfer(1, 8'(b * 17 + 3), rx, last, 1'b0);
            last = rx;
        end

        // R3 external pin source
        for (int b = 0; b < 8; b++) begin
            logic [7:0] rx;
            rx = 8'(b * 53) ^ 8'h3C;
            xfer(2, 8'(b * 41 + 200), rx, last, 1'b0);
            last = rx;
        end

        // R7 pulse bits read as zero, toggle and strobe together
        bus_wr(2'd1, 8'h80);
        bus_wr(2'd0, 8'h65);
        bus_rd(2'd0, v); chk("R7 control readback", v, 8'h05);
        bus_rd(2'd1, v); chk("R7 strobe with toggle counted", v, 8'h01);
        chk("R7 toggle with strobe", {7'd0, sck_out}, 8'h01);
        bus_wr(2'd0, 8'h44);
        chk("R7 toggle alone", {7'd0, sck_out}, 8'h00);

        // R2 mode gating
        bus_wr(2'd2, 8'h3C);
        bus_wr(2'd1, 8'h80);
        bus_wr(2'd0, 8'h24);
        bus_wr(2'd0, 8'h24);
        bus_wr(2'd0, 8'h26);
        bus_wr(2'd0, 8'h27);
        bus_rd(2'd1, v); chk("R2 count frozen off-mode", v, 8'h00);
        bus_rd(2'd2, v); chk("R2 data frozen off-mode", v, 8'h3C);

        // R3 non-selected sources ignored
        bus_wr(2'd0, 8'h05);
        pulse_tmr(); pulse_tmr();
        ext_edge(); ext_edge();
        bus_rd(2'd1, v); chk("R3 timer/pin ignored under strobe", v, 8'h00);
        bus_wr(2'd0, 8'h29);
        bus_wr(2'd0, 8'h29);
        bus_rd(2'd1, v); chk("R3 strobe ignored under timer", v, 8'h00);
        bus_wr(2'd0, 8'h01);
        pulse_tmr();
        bus_wr(2'd0, 8'h21);
        bus_rd(2'd1, v); chk("R3 no source selected", v, 8'h00);
        bus_rd(2'd2, v); chk("R3 data untouched", v, 8'h3C);

        // R8 external synchronizer latency
        bus_wr(2'd0, 8'h0D);
        bus_wr(2'd1, 8'h80);
        @(negedge clk); sck_in = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_rd(2'd1, v); chk("R8 not counted after two edges", v, 8'h00);
        @(negedge clk);
        bus_rd(2'd1, v); chk("R8 counted at third edge", v, 8'h01);
        ext_edge();
        bus_rd(2'd1, v); chk("R8 falling edge counted", v, 8'h02);

        // R9 write priorities against timer events
        bus_wr(2'd0, 8'h09);
        bus_wr(2'd1, 8'h81);
        @(negedge clk); addr = 2'd2; wdata = 8'h5A; we = 1'b1; tmr = 1'b1;
        @(negedge clk); we = 1'b0; tmr = 1'b0;
        bus_rd(2'd2, v); chk("R9 data write beats shift", v, 8'h5A);
        bus_rd(2'd1, v); chk("R9 count still advanced", v, 8'h02);
        @(negedge clk); addr = 2'd1; wdata = 8'h07; we = 1'b1; tmr = 1'b1;
        @(negedge clk); we = 1'b0; tmr = 1'b0;
        bus_rd(2'd1, v); chk("R9 status write beats count", v, 8'h07);

        // R4 flag set and write-one-to-clear
        bus_wr(2'd1, 8'h0F);
        pulse_tmr();
        bus_rd(2'd1, v); chk("R4 wrap from 15", v, 8'h80);
        bus_wr(2'd1, 8'h0F);
        bus_rd(2'd1, v); chk("R4 flag kept on zero write", v, 8'h8F);
        bus_wr(2'd1, 8'h80);
        bus_rd(2'd1, v); chk("R4 flag cleared by one", v, 8'h00);

        // R6 buffer writes ignored
        bus_rd(2'd3, last);
        bus_wr(2'd3, ~last);
        bus_rd(2'd3, v); chk("R6 buffer write ignored", v, last);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule